// File: doc/BRIEF.md
# Asynchronous SRAM Cycle Controller

This block sits between a clocked request/response port and an external asynchronous static RAM of 64K bytes. A client offers one read or one write at a time. The controller converts it into a strobe sequence on the memory pins that meets the part's minimum intervals. The pins are a 16-bit address, a low-active select, a high-active select, a low-active output enable, a low-active write strobe, and a data bus split into an outgoing value, an incoming value and a drive enable.

Every timing limit is held in nanoseconds for two speed grades: 55 ns and 70 ns. Each limit becomes a cycle count by rounding its nanosecond value up to whole periods of a configured clock period, with a floor of one cycle. Writes are ended by the write strobe, with output enable held inactive throughout. After output enable is released, the controller waits a bus-turnaround interval before it drives the data bus. This keeps the controller and the memory from driving the bus at the same time.

Top module: `sram_cycle_ctl`

## Requirements
- R1: While reset is high, and after it, until a request arrives: both selects are inactive (low-active select 1, high-active select 0), output enable is 1, the write strobe is 1, the data driver is off, done is 0 and ready is 1.
- R2: Ready is high only while no transaction is in progress. A request is taken on a clock edge where valid and ready are both 1. Ready drops on that edge. Changes to the request inputs after that edge have no effect on the transaction.
- R3: A read drives low-active select 0, high-active select 1, output enable 0 and write strobe 1. The address stays constant for as long as that condition lasts, and the data driver stays off.
- R4: Read data is taken from the bus on the edge that comes N_AA+1 cycles after the read strobes assert, where N_AA is the rounded address-to-data time. It is returned on the read-data output together with done.
- R5: The write strobe is low for exactly N_PLS cycles. N_PLS is the largest of the rounded write-pulse, select-to-end, address-to-end and data-setup times. Output enable is 1 for the whole write.
- R6: The write strobe rises first. Both selects, the address, the drive enable and the driven data are all unchanged for at least one cycle after that rise.
- R7: The data driver is on only while output enable is 1. It turns on no sooner than N_HZ+1 cycles after output enable last rose, where N_HZ is the rounded release time.
- R8: Each transaction produces exactly one done pulse, one cycle wide, for reads and for writes alike.
- R9: Two successive select assertions are at least N_CYC cycles apart, where N_CYC is the rounded cycle time.
- R10: At a 5 ns period with the 55 ns grade, the counts are N_AA=11, N_PLS=9, N_HZ=4 and N_CYC=11. At a 4 ns period with the 70 ns grade, rounding up gives N_AA=18, N_PLS=15, N_HZ=7 and N_CYC=18.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_valid | input | 1 | Request offered |
| req_write | input | 1 | 1 = write, 0 = read |
| req_addr | input | AW | Request address |
| req_wdata | input | DW | Write data |
| req_ready | output | 1 | Controller idle, can accept |
| rsp_done | output | 1 | One-cycle completion pulse |
| rsp_rdata | output | DW | Read data, valid with done |
| mem_addr | output | AW | Memory address pins |
| mem_cs_n | output | 1 | Low-active select |
| mem_cs | output | 1 | High-active select |
| mem_oe_n | output | 1 | Low-active output enable |
| mem_we_n | output | 1 | Low-active write strobe |
| mem_dq_out | output | DW | Data driven to memory |
| mem_dq_in | input | DW | Data read from memory bus |
| mem_dq_oe | output | 1 | Data driver enable |

## Verification
The bench's memory model returns a poison byte until the read condition has lasted longer than the access count. A controller that samples one edge early therefore reads back the wrong data. Writes issued straight after reads test the turnaround: a design that drives as soon as output enable rises is reported as bus contention by the model. The model also measures the exact write-strobe width and checks the hold cycle after the rise. This exposes a select or data released together with the strobe, and a pulse cut short. Request inputs are scrambled right after acceptance, so a design that does not latch them writes or reads the wrong location. A second instance with the slower grade and a 4 ns configured period checks that the counts are rounded up.

// File: rtl/sram_ctl_pkg.sv
`timescale 1ns/1ps
package sram_ctl_pkg;

  typedef enum logic [2:0] {
    ST_IDLE, ST_RD_ACC, ST_RD_SMP, ST_WR_SET, ST_WR_PLS, ST_WR_HLD, ST_RECOV
  } st_e;

  // nanosecond limits of one speed grade
  typedef struct packed {
    int unsigned cyc;   // read / write cycle
    int unsigned acc;   // address to data
    int unsigned sel;   // select to write end
    int unsigned adr;   // address setup to write end
    int unsigned pls;   // strobe width
    int unsigned dsu;   // data setup to write end
    int unsigned rel;   // bus release after output enable off
  } grade_t;

  function automatic grade_t grade_ns(bit fast);
    grade_t g;
    if (fast) g = '{cyc: 55, acc: 55, sel: 45, adr: 45, pls: 40, dsu: 25, rel: 20};
    else      g = '{cyc: 70, acc: 70, sel: 60, adr: 60, pls: 55, dsu: 30, rel: 25};
    return g;
  endfunction

  function automatic int unsigned ns_to_cyc(int unsigned ns, int unsigned per);
    int unsigned c;
    c = (ns + per - 1) / per;
    return (c == 0) ? 1 : c;
  endfunction

  function automatic int unsigned umax(int unsigned x, int unsigned y);
    return (x > y) ? x : y;
  endfunction

endpackage

// File: rtl/sram_ctl_timer.sv
`timescale 1ns/1ps
module sram_ctl_timer #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load,
  input  logic [W-1:0] load_val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst)                cnt_q <= '0;
    else if (load)          cnt_q <= load_val;
    else if (cnt_q != '0)   cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);

  // a nonzero load must keep the interval open on the following cycle
  a_r9_load_open: assert property (@(posedge clk) disable iff (rst)
    (load && load_val != '0) |=> !zero);

endmodule

// File: rtl/sram_ctl_turn.sv
`timescale 1ns/1ps
module sram_ctl_turn #(
  parameter int unsigned N_HZ = 4,
  parameter int          W    = 4
) (
  input  logic clk,
  input  logic rst,
  input  logic oe_n,
  output logic free
);
  logic [W-1:0] age_q;

  // cycles since output enable went inactive, saturating at N_HZ
  always_ff @(posedge clk) begin
    if (rst)                     age_q <= W'(N_HZ);
    else if (!oe_n)              age_q <= '0;
    else if (age_q != W'(N_HZ))  age_q <= age_q + 1'b1;
  end

  assign free = (age_q == W'(N_HZ));

  a_r7_age_bound: assert property (@(posedge clk) disable iff (rst)
    age_q <= W'(N_HZ));
  a_r7_restart: assert property (@(posedge clk) disable iff (rst)
    $fell(oe_n) |=> !free);

endmodule

// File: rtl/sram_cycle_ctl.sv
`timescale 1ns/1ps
module sram_cycle_ctl
  import sram_ctl_pkg::*;
#(
  parameter int AW         = 16,
  parameter int DW         = 8,
  parameter int CLK_NS     = 5,
  parameter bit FAST_GRADE = 1'b1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          req_valid,
  input  logic          req_write,
  input  logic [AW-1:0] req_addr,
  input  logic [DW-1:0] req_wdata,
  output logic          req_ready,
  output logic          rsp_done,
  output logic [DW-1:0] rsp_rdata,
  output logic [AW-1:0] mem_addr,
  output logic          mem_cs_n,
  output logic          mem_cs,
  output logic          mem_oe_n,
  output logic          mem_we_n,
  output logic [DW-1:0] mem_dq_out,
  input  logic [DW-1:0] mem_dq_in,
  output logic          mem_dq_oe
);
  localparam grade_t      TG    = grade_ns(FAST_GRADE);
  localparam int unsigned N_AA  = ns_to_cyc(TG.acc, CLK_NS);
  localparam int unsigned N_PLS = umax(umax(ns_to_cyc(TG.sel, CLK_NS), ns_to_cyc(TG.adr, CLK_NS)),
                                       umax(ns_to_cyc(TG.pls, CLK_NS), ns_to_cyc(TG.dsu, CLK_NS)));
  localparam int unsigned N_HZ  = ns_to_cyc(TG.rel, CLK_NS);
  localparam int unsigned N_CYC = ns_to_cyc(TG.cyc, CLK_NS);
  localparam int unsigned N_MAX = umax(umax(N_AA, N_PLS), umax(N_HZ, N_CYC));
  localparam int          CW    = $clog2(N_MAX + 1);

  st_e           state;
  logic          take;
  logic          ph_load, ph_zero;
  logic [CW-1:0] ph_val;
  logic          span_zero;
  logic          turn_free;

  assign req_ready = (state == ST_IDLE);
  assign take      = req_ready && req_valid;

  // phase timer: read access window or write strobe width
  assign ph_load = (take && !req_write) || (state == ST_WR_SET && turn_free);
  assign ph_val  = (state == ST_IDLE) ? CW'(N_AA - 1) : CW'(N_PLS - 1);

  sram_ctl_timer #(.W(CW)) u_phase (
    .clk(clk), .rst(rst), .load(ph_load), .load_val(ph_val), .zero(ph_zero)
  );

  // span timer: minimum cycle time from acceptance
  sram_ctl_timer #(.W(CW)) u_span (
    .clk(clk), .rst(rst), .load(take), .load_val(CW'(N_CYC - 1)), .zero(span_zero)
  );

  sram_ctl_turn #(.N_HZ(N_HZ), .W(CW)) u_turn (
    .clk(clk), .rst(rst), .oe_n(mem_oe_n), .free(turn_free)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      mem_addr   <= '0;
      mem_dq_out <= '0;
      rsp_rdata  <= '0;
      mem_cs_n   <= 1'b1;
      mem_cs     <= 1'b0;
      mem_oe_n   <= 1'b1;
      mem_we_n   <= 1'b1;
      mem_dq_oe  <= 1'b0;
      rsp_done   <= 1'b0;
    end else begin
      rsp_done <= 1'b0;
      case (state)
        ST_IDLE: if (req_valid) begin
          mem_addr   <= req_addr;
          mem_dq_out <= req_wdata;
          mem_cs_n   <= 1'b0;
          mem_cs     <= 1'b1;
          if (req_write) begin
            state <= ST_WR_SET;
          end else begin
            mem_oe_n <= 1'b0;
            state    <= ST_RD_ACC;
          end
        end
        ST_RD_ACC: if (ph_zero) state <= ST_RD_SMP;
        ST_RD_SMP: begin
          rsp_rdata <= mem_dq_in;
          rsp_done  <= 1'b1;
          mem_cs_n  <= 1'b1;
          mem_cs    <= 1'b0;
          mem_oe_n  <= 1'b1;
          state     <= ST_RECOV;
        end
        ST_WR_SET: if (turn_free) begin
          mem_we_n  <= 1'b0;
          mem_dq_oe <= 1'b1;
          state     <= ST_WR_PLS;
        end
        ST_WR_PLS: if (ph_zero) begin
          mem_we_n <= 1'b1;
          state    <= ST_WR_HLD;
        end
        ST_WR_HLD: begin
          mem_cs_n  <= 1'b1;
          mem_cs    <= 1'b0;
          mem_dq_oe <= 1'b0;
          rsp_done  <= 1'b1;
          state     <= ST_RECOV;
        end
        ST_RECOV: if (span_zero) state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  a_r2_idle_quiet: assert property (@(posedge clk) disable iff (rst)
    req_ready |-> (mem_cs_n && !mem_cs && mem_we_n && mem_oe_n && !mem_dq_oe));
  a_r3_read_pins: assert property (@(posedge clk) disable iff (rst)
    !mem_oe_n |-> (!mem_cs_n && mem_cs && mem_we_n && !mem_dq_oe));
  a_r5_write_pins: assert property (@(posedge clk) disable iff (rst)
    !mem_we_n |-> (mem_oe_n && mem_dq_oe && !mem_cs_n && mem_cs));
  a_r6_strobe_first: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_we_n) |-> (!mem_cs_n && mem_cs && mem_dq_oe && $stable(mem_addr) && $stable(mem_dq_out)));
  a_r7_bus_owner: assert property (@(posedge clk) disable iff (rst)
    mem_dq_oe |-> mem_oe_n);
  a_r7_turn_wait: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_dq_oe) |-> turn_free);
  a_r8_done_pulse: assert property (@(posedge clk) disable iff (rst)
    rsp_done |=> !rsp_done);

endmodule

// File: tb/sram_cycle_ctl_test.sv
`timescale 1ns/1ps
module sram_model #(
  parameter int AA = 11, parameter int PULSE = 9, parameter int HZ = 4,
  parameter int CYC = 11, parameter int ID = 0
) (
  input  logic        clk,
  input  logic [15:0] addr,
  input  logic        cs_n,
  input  logic        cs,
  input  logic        oe_n,
  input  logic        we_n,
  input  logic [7:0]  dq_out,
  input  logic        dq_oe,
  output logic [7:0]  dq_in,
  output int          checks,
  output int          errs,
  output int          last_pulse
);
  logic [7:0]  mem [256];
  int          rage, oe_age, pw, gap;
  logic        wr_prev, sel_prev;
  logic [15:0] pa, pr;
  logic [7:0]  pd;

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    checks = 0; errs = 0; last_pulse = 0;
    rage = 0; oe_age = 1000; pw = 0; gap = 1000;
    wr_prev = 1'b0; sel_prev = 1'b0; pa = '0; pr = '0; pd = '0;
    dq_in = 8'hEE;
  end

  task automatic fail(input string req, input int act, input int exp);
    errs++;
    $display("FAIL %s (mem%0d) actual=%0d expected=%0d", req, ID, act, exp);
  endtask

  always @(negedge clk) begin
    logic sel, rd, wr;
    sel = !cs_n && cs;
    rd  = sel && !oe_n && we_n;
    wr  = sel && !we_n;
    // R7: controller may drive only while memory is released
    if (!oe_n) oe_age = 0; else if (oe_age < 1000) oe_age++;
    if (dq_oe) begin
      checks++;
      if (rd || oe_age <= HZ) fail("R7 contention", oe_age, HZ + 1);
    end
    // R3 / R4: access age, poison until age exceeds AA
    if (rd) begin
      if (rage > 0 && addr != pr) fail("R3 address moved", addr, pr);
      rage++; pr = addr;
    end else rage = 0;
    dq_in = (rd && rage > AA) ? mem[addr[7:0]] : 8'hEE;
    // R5 / R6: write strobe width and hold
    if (wr) begin
      checks++;
      if (!oe_n) fail("R5 oe during write", 0, 1);
      if (pw > 0 && (addr != pa || dq_out != pd)) fail("R6 changed in pulse", addr, pa);
      pw++; pa = addr; pd = dq_out;
    end else if (wr_prev) begin
      checks++;
      last_pulse = pw;
      if (pw != PULSE) fail("R5 pulse width", pw, PULSE);
      if (!(sel && dq_oe && addr == pa && dq_out == pd)) fail("R6 hold after strobe", 0, 1);
      mem[pa[7:0]] = pd;
      pw = 0;
    end
    wr_prev = wr;
    // R9: spacing between selects
    if (sel && !sel_prev) begin
      checks++;
      if (gap < CYC - 1) fail("R9 cycle spacing", gap + 1, CYC);
      gap = 0;
    end else if (gap < 1000) gap++;
    sel_prev = sel;
  end
endmodule

module sram_cycle_ctl_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2.5 clk = ~clk;

  logic        v [2], w [2];
  logic [15:0] a [2];
  logic [7:0]  d [2];
  logic        rdy [2], done [2];
  logic [7:0]  rd [2];
  logic [15:0] ma [2];
  logic        csn [2], cs [2], oen [2], wen [2], dqe [2];
  logic [7:0]  dqo [2], dqi [2];
  int          mchk [2], merr [2], mpls [2];

  int   nchk = 0, nbad = 0;
  int   ntx [2], ndone [2];
  logic dprev [2];
  logic [7:0] shadow [2][256];

  sram_cycle_ctl #(.CLK_NS(5), .FAST_GRADE(1'b1)) uut (
    .clk(clk), .rst(rst), .req_valid(v[0]), .req_write(w[0]), .req_addr(a[0]),
    .req_wdata(d[0]), .req_ready(rdy[0]), .rsp_done(done[0]), .rsp_rdata(rd[0]),
    .mem_addr(ma[0]), .mem_cs_n(csn[0]), .mem_cs(cs[0]), .mem_oe_n(oen[0]),
    .mem_we_n(wen[0]), .mem_dq_out(dqo[0]), .mem_dq_in(dqi[0]), .mem_dq_oe(dqe[0]));

  sram_cycle_ctl #(.CLK_NS(4), .FAST_GRADE(1'b0)) uut_slow (
    .clk(clk), .rst(rst), .req_valid(v[1]), .req_write(w[1]), .req_addr(a[1]),
    .req_wdata(d[1]), .req_ready(rdy[1]), .rsp_done(done[1]), .rsp_rdata(rd[1]),
    .mem_addr(ma[1]), .mem_cs_n(csn[1]), .mem_cs(cs[1]), .mem_oe_n(oen[1]),
    .mem_we_n(wen[1]), .mem_dq_out(dqo[1]), .mem_dq_in(dqi[1]), .mem_dq_oe(dqe[1]));

  // R10 expected counts: 55 ns grade at 5 ns, 70 ns grade at 4 ns (rounded up)
  sram_model #(.AA(11), .PULSE(9), .HZ(4), .CYC(11), .ID(0)) m0 (
    .clk(clk), .addr(ma[0]), .cs_n(csn[0]), .cs(cs[0]), .oe_n(oen[0]), .we_n(wen[0]),
    .dq_out(dqo[0]), .dq_oe(dqe[0]), .dq_in(dqi[0]),
    .checks(mchk[0]), .errs(merr[0]), .last_pulse(mpls[0]));
  sram_model #(.AA(18), .PULSE(15), .HZ(7), .CYC(18), .ID(1)) m1 (
    .clk(clk), .addr(ma[1]), .cs_n(csn[1]), .cs(cs[1]), .oe_n(oen[1]), .we_n(wen[1]),
    .dq_out(dqo[1]), .dq_oe(dqe[1]), .dq_in(dqi[1]),
    .checks(mchk[1]), .errs(merr[1]), .last_pulse(mpls[1]));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    nchk++;
    if (!ok) begin
      nbad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("  test done: total=%0d bad=%0d", nchk + mchk[0] + mchk[1], nbad + merr[0] + merr[1]);
  endtask

  // R8: done is a single-cycle pulse
  always @(negedge clk) begin
    for (int k = 0; k < 2; k++) begin
      if (!rst && done[k]) begin
        ndone[k]++;
        chk(!dprev[k], "R8 done wider than one cycle", 1, 0);
      end
      dprev[k] = done[k];
    end
  end

  task automatic one(input int k, input bit wr, input [15:0] ad, input [7:0] da, output [7:0] got);
    @(negedge clk);
    v[k] = 1'b1; w[k] = wr; a[k] = ad; d[k] = da;
    while (!rdy[k]) @(negedge clk);
    @(negedge clk);
    // R2: scramble request fields once accepted
    v[k] = 1'b0; w[k] = !wr; a[k] = ~ad; d[k] = ~da;
    chk(!rdy[k], "R2 ready after accept", rdy[k], 0);
    while (!done[k]) @(negedge clk);
    got = rd[k];
    ntx[k]++;
  endtask

  task automatic xfer(input bit wr, input [15:0] ad, input [7:0] da);
    logic [7:0] g0, g1;
    fork
      one(0, wr, ad, da, g0);
      one(1, wr, ad, da ^ 8'h5A, g1);
    join
    if (wr) begin
      shadow[0][ad[7:0]] = da;
      shadow[1][ad[7:0]] = da ^ 8'h5A;
    end else begin
      chk(g0 == shadow[0][ad[7:0]], "R4 read data fast grade", g0, shadow[0][ad[7:0]]);
      chk(g1 == shadow[1][ad[7:0]], "R4 read data slow grade", g1, shadow[1][ad[7:0]]);
    end
  endtask

  task automatic t_reset();
    repeat (3) @(posedge clk);
    @(negedge clk);
    for (int k = 0; k < 2; k++) begin
      chk(csn[k] && !cs[k] && oen[k] && wen[k], "R1 strobes idle in reset", {csn[k], cs[k], oen[k], wen[k]}, 4'b1011);
      chk(!dqe[k] && !done[k] && rdy[k], "R1 driver off, ready", {dqe[k], done[k], rdy[k]}, 3'b001);
    end
    rst = 1'b0;
    repeat (2) @(negedge clk);
    chk(rdy[0] && csn[0] && !dqe[0], "R1 idle after reset", {rdy[0], csn[0], dqe[0]}, 3'b110);
  endtask

  task automatic t_unwritten_read();
    xfer(1'b0, 16'h7733, 8'h00);  // R4: fresh location reads zero
  endtask

  task automatic t_write_then_read();  // R3 R5 R6
    xfer(1'b1, 16'h1201, 8'hA5);
    xfer(1'b1, 16'hFE02, 8'h3C);
    xfer(1'b1, 16'h0003, 8'hFF);
    xfer(1'b0, 16'h1201, 8'h00);
    xfer(1'b0, 16'hFE02, 8'h00);
    xfer(1'b0, 16'h0003, 8'h00);
  endtask

  task automatic t_turnaround();  // R7: write right behind a read
    xfer(1'b0, 16'h1201, 8'h00);
    xfer(1'b1, 16'h4410, 8'h81);
    xfer(1'b0, 16'h4410, 8'h00);
    xfer(1'b1, 16'h4410, 8'h18);
    xfer(1'b0, 16'h4410, 8'h00);
  endtask

  task automatic t_grade();  // R10 R5
    chk(mpls[0] == 9,  "R10 fast grade pulse cycles", mpls[0], 9);
    chk(mpls[1] == 15, "R10 slow grade pulse cycles", mpls[1], 15);
  endtask

  task automatic t_done_count();  // R8
    repeat (3) @(negedge clk);
    chk(ndone[0] == ntx[0], "R8 one done per transaction (fast)", ndone[0], ntx[0]);
    chk(ndone[1] == ntx[1], "R8 one done per transaction (slow)", ndone[1], ntx[1]);
    chk(mchk[0] > 0 && mchk[1] > 0, "R9 spacing and bus checks ran", mchk[0], 1);
  endtask

  initial begin
    for (int k = 0; k < 2; k++) begin
      v[k] = 1'b0; w[k] = 1'b0; a[k] = '0; d[k] = '0;
      ntx[k] = 0; ndone[k] = 0; dprev[k] = 1'b0;
      for (int i = 0; i < 256; i++) shadow[k][i] = 8'h00;
    end
    t_reset();
    t_unwritten_read();
    t_write_then_read();
    t_turnaround();
    t_grade();
    t_done_count();
    report();
    $finish;
  end

  initial begin
    repeat (50000) @(posedge clk);
    nchk++; nbad++;
    $display("FAIL watchdog expired actual=1 expected=0");
    report();
    $finish;
  end
endmodule